// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block raises and retires doorbell interrupts between the two sides of a shared two-port memory. Each side presents a chip select, an output enable, a write strobe, a word address and a busy input. The block decodes all of these, but it does not model the storage array. It drives one active-low interrupt line toward each side. The two highest word addresses serve as mailboxes. The second-highest address belongs to the left side, and the highest belongs to the right side.

A side sends a message by writing the mailbox that belongs to the other side. That write raises the other side's interrupt. The receiving side retires its interrupt by accessing its own mailbox. An access means that chip select and output enable are both low, and the level of the write strobe does not matter. Each side's busy input comes from the collision arbiter. While it is low, that side can neither raise nor retire a flag. The mailbox words hold ordinary data, so the block never alters the memory.

All strobes are sampled on the rising clock edge. An interrupt output changes at the first rising edge after the cycle that carries the qualifying operation. Because the block only observes the memory strobes and produces level outputs, it has no streaming interface and no back-pressure.

Top module: `dp_mailbox_irq`

## Requirements
- R1: While reset is low, and at the first clock edge after it rises, both interrupt outputs are high (inactive).
- R2: A right-side write goes to address 2^ADDR_W-2 (0x7FE for 11 bits). A write means chip select low and write strobe low, with right busy high. After the next clock edge, the left interrupt output is low.
- R3: A left-side write goes to address 2^ADDR_W-1 (0x7FF), with left busy high. After the next clock edge, the right interrupt output is low.
- R4: A left-side access to 0x7FE means chip select low and output enable low, with any write strobe level and left busy high. After the next clock edge, the left interrupt output is high, unless R8 applies.
- R5: A right-side access to 0x7FF, with right busy high, drives the right interrupt output high after the next clock edge, unless R8 applies.
- R6: While a side's busy input is low, a write or an access by that side leaves both interrupt outputs unchanged.
- R7: No other operation changes either interrupt output. This covers other addresses, chip select high, write strobe high for setting, output enable high for clearing, a write to a side's own mailbox, and an access to the far mailbox.
- R8: A set and a clear of the same flag may fall in one cycle. In that case the flag ends up set, so its output is low.
- R9: A flag that is already set stays set when the far side writes the mailbox again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel_n | input | 1 | Left chip select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_addr | input | ADDR_W | Left word address |
| l_busy_n | input | 1 | Left busy from arbiter, active low |
| r_sel_n | input | 1 | Right chip select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_addr | input | ADDR_W | Right word address |
| r_busy_n | input | 1 | Right busy from arbiter, active low |
| l_irq_n | output | 1 | Interrupt toward left side, active low, always driven |
| r_irq_n | output | 1 | Interrupt toward right side, active low, always driven |

## Verification
The bench sweeps every combination of both sides' four strobes against three addresses per side: each mailbox and one ordinary word. It runs that sweep from all four starting flag states and predicts each flag arithmetically. The sweep catches several errors.
- A swapped mailbox assignment would let a side interrupt itself.
- A clear that requires the write strobe high would miss clears made during writes.
- A decoder that ignores busy, or that gates on the wrong side's busy, would move flags during collisions.
- A clear-priority register would drop a message that lands while the receiver is reading its mailbox.

// File: rtl/dp_mailbox_pkg.sv
package dp_mailbox_pkg;
  typedef enum logic { SIDE_L = 1'b0, SIDE_R = 1'b1 } side_e;

  // Mailbox owned by a side: left owns top-1, right owns top.
  function automatic logic [31:0] mbox_of(side_e s, int aw);
    logic [31:0] top;
    top = (32'd1 << aw) - 32'd1;
    return (s == SIDE_L) ? top - 32'd1 : top;
  endfunction
endpackage

// File: rtl/dp_mailbox_decode.sv
module dp_mailbox_decode
  import dp_mailbox_pkg::*;
#(
  parameter int    ADDR_W = 11,
  parameter side_e SIDE   = SIDE_L
) (
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy_n,
  output logic              post,
  output logic              take
);
  localparam side_e PEER = (SIDE == SIDE_L) ? SIDE_R : SIDE_L;
  localparam logic [ADDR_W-1:0] OWN_BOX  = ADDR_W'(mbox_of(SIDE, ADDR_W));
  localparam logic [ADDR_W-1:0] PEER_BOX = ADDR_W'(mbox_of(PEER, ADDR_W));

  logic granted;
  assign granted = !sel_n && busy_n;

  // A write into the peer's mailbox posts a message.
  assign post = granted && !wr_n && (addr == PEER_BOX);
  // An access to the own mailbox takes the message; the write strobe is not looked at.
  assign take = granted && !oe_n && (addr == OWN_BOX);
endmodule

// File: rtl/dp_mailbox_flag.sv
module dp_mailbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (set_req) pending <= 1'b1;   // set outranks clear
    else if (clr_req) pending <= 1'b0;
  end

  assign irq_n = !pending;
endmodule

// File: rtl/dp_mailbox_irq.sv
module dp_mailbox_irq
  import dp_mailbox_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel_n,
  input  logic              l_oe_n,
  input  logic              l_wr_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy_n,
  input  logic              r_sel_n,
  input  logic              r_oe_n,
  input  logic              r_wr_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy_n,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0] sel_n, oe_n, wr_n, busy_n, post, take, irq_n;
  logic [ADDR_W-1:0] addr [NSIDE];

  assign sel_n  = {r_sel_n,  l_sel_n};
  assign oe_n   = {r_oe_n,   l_oe_n};
  assign wr_n   = {r_wr_n,   l_wr_n};
  assign busy_n = {r_busy_n, l_busy_n};
  assign addr[0] = l_addr;
  assign addr[1] = r_addr;

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    dp_mailbox_decode #(
      .ADDR_W(ADDR_W),
      .SIDE  ((i == 0) ? SIDE_L : SIDE_R)
    ) u_dec (
      .sel_n (sel_n[i]),
      .oe_n  (oe_n[i]),
      .wr_n  (wr_n[i]),
      .addr  (addr[i]),
      .busy_n(busy_n[i]),
      .post  (post[i]),
      .take  (take[i])
    );

    // Flag of side i: posted by the other side, taken by side i.
    dp_mailbox_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_req(post[NSIDE-1-i]),
      .clr_req(take[i]),
      .irq_n  (irq_n[i])
    );
  end

  assign l_irq_n = irq_n[0];
  assign r_irq_n = irq_n[1];
endmodule

// File: rtl/dp_mailbox_irq_chk.sv
module dp_mailbox_irq_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_sel_n,
  input logic              l_oe_n,
  input logic              l_wr_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy_n,
  input logic              r_sel_n,
  input logic              r_oe_n,
  input logic              r_wr_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_n,
  input logic              l_irq_n,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

  logic rw_to_l, lw_to_r, l_reads, r_reads;
  assign rw_to_l = !r_sel_n && !r_wr_n && r_busy_n && (r_addr == BOX_L);
  assign lw_to_r = !l_sel_n && !l_wr_n && l_busy_n && (l_addr == BOX_R);
  assign l_reads = !l_sel_n && !l_oe_n && l_busy_n && (l_addr == BOX_L);
  assign r_reads = !r_sel_n && !r_oe_n && r_busy_n && (r_addr == BOX_R);

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (l_irq_n && r_irq_n));
  // R2
  set_left_chk: assert property (@(posedge clk) disable iff (!rst_n) rw_to_l |=> !l_irq_n);
  // R3
  set_right_chk: assert property (@(posedge clk) disable iff (!rst_n) lw_to_r |=> !r_irq_n);
  // R4
  clr_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_reads && !rw_to_l) |=> l_irq_n);
  // R5
  clr_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_reads && !lw_to_r) |=> r_irq_n);
  // R6
  hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_to_l && !l_reads) |=> $stable(l_irq_n));
  // R7
  hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lw_to_r && !r_reads) |=> $stable(r_irq_n));
endmodule

bind dp_mailbox_irq dp_mailbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_dp_mailbox_irq.sv
module tb_dp_mailbox_irq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam logic [AW-1:0] BOX_R = {AW{1'b1}};
  localparam logic [AW-1:0] BOX_L = BOX_R - 1'b1;
  localparam logic [AW-1:0] PLAIN = 11'h123;

  logic clk = 1'b0;
  logic rst_n;
  logic l_sel_n, l_oe_n, l_wr_n, l_busy_n, r_sel_n, r_oe_n, r_wr_n, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_mailbox_irq #(.ADDR_W(AW)) dut (.*);

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    l_sel_n = 1; l_oe_n = 1; l_wr_n = 1; l_busy_n = 1; l_addr = PLAIN;
    r_sel_n = 1; r_oe_n = 1; r_wr_n = 1; r_busy_n = 1; r_addr = PLAIN;
  endtask

  function automatic logic [AW-1:0] addr_of(input int k);
    return (k == 0) ? BOX_L : (k == 1) ? BOX_R : PLAIN;
  endfunction

  // ctrl bits: [0] sel_n, [1] oe_n, [2] wr_n, [3] busy_n
  function automatic string tag_of(input bit set, input bit clr, input bit was,
                                   input bit gated, input bit left);
    if (set && clr) return "R8";
    if (set && was) return "R9";
    if (set)        return left ? "R2" : "R3";
    if (clr)        return left ? "R4" : "R5";
    if (gated)      return "R6";
    return "R7";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    #1;
    check(l_irq_n, 1'b1, "R1 left during reset");
    check(r_irq_n, 1'b1, "R1 right during reset");
    for (int s = 0; s < 4; s++)
      for (int lc = 0; lc < 16; lc++)
        for (int la = 0; la < 3; la++)
          for (int rc = 0; rc < 16; rc++)
            for (int ra = 0; ra < 3; ra++) begin
              bit fl, fr, set_l, set_r, clr_l, clr_r, g_l, g_r, nl, nr;
              logic [3:0] lv, rv;
              lv = 4'(lc); rv = 4'(rc);
              // reset cycle
              @(negedge clk); idle(); rst_n = 0;
              @(negedge clk); rst_n = 1;
              check(l_irq_n, 1'b1, "R1 left after reset");
              check(r_irq_n, 1'b1, "R1 right after reset");
              // establish starting state
              fl = s[0]; fr = s[1];
              if (fl) begin r_sel_n = 0; r_wr_n = 0; r_addr = BOX_L; end
              if (fr) begin l_sel_n = 0; l_wr_n = 0; l_addr = BOX_R; end
              @(negedge clk);
              check(l_irq_n, !fl, "R2 setup");
              check(r_irq_n, !fr, "R3 setup");
              // operation under test
              l_sel_n = lv[0]; l_oe_n = lv[1]; l_wr_n = lv[2]; l_busy_n = lv[3];
              l_addr = addr_of(la);
              r_sel_n = rv[0]; r_oe_n = rv[1]; r_wr_n = rv[2]; r_busy_n = rv[3];
              r_addr = addr_of(ra);
              set_l = !rv[0] && !rv[2] && rv[3] && ra == 0;
              set_r = !lv[0] && !lv[2] && lv[3] && la == 1;
              clr_l = !lv[0] && !lv[1] && lv[3] && la == 0;
              clr_r = !rv[0] && !rv[1] && rv[3] && ra == 1;
              g_l = (!rv[3] && !rv[0] && !rv[2] && ra == 0) ||
                    (!lv[3] && !lv[0] && !lv[1] && la == 0);
              g_r = (!lv[3] && !lv[0] && !lv[2] && la == 1) ||
                    (!rv[3] && !rv[0] && !rv[1] && ra == 1);
              nl = set_l || (fl && !clr_l);
              nr = set_r || (fr && !clr_r);
              @(negedge clk);
              check(l_irq_n, !nl, tag_of(set_l, clr_l, fl, g_l, 1'b1));
              check(r_irq_n, !nr, tag_of(set_r, clr_r, fr, g_r, 1'b0));
              idle();
            end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule